// File: doc/BRIEF.md
# Destination Address Receive Filter

This block sits on the receive byte stream of an Ethernet MAC. It looks at the destination address, which is the first six octets of each incoming frame, as those octets arrive. It produces one accept or reject verdict before the rest of the frame is passed on. A frame-start strobe marks each new frame and re-arms the filter. The octets then arrive one per cycle while `oct_valid` is high, and idle cycles may fall between them.

The verdict follows a fixed priority:

1. Reception must be enabled.
2. Promiscuous mode passes everything.
3. Otherwise the frame passes on an exact match with the programmed station address.
4. Failing that, it passes on the all-ones broadcast address.
5. Failing that, it passes when hashing is enabled and a 64-bit multicast table has the bit selected by a CRC of the address.

The CRC is computed one byte per cycle while the address streams in, so no address buffer is needed. The station address and hash table are plain inputs, driven from registers elsewhere in the MAC.

Top module: `rx_dest_filter`

## Requirements
- R1: While `cfg_rx_en` is 0 when the sixth octet is taken, the verdict is reject, whatever the address and other mode bits.
- R2: With `cfg_rx_en` and `cfg_promisc` both 1, every frame is accepted regardless of its address.
- R3: A frame is accepted when its octets 0..5 equal, in order, `sta_w0[15:8]`, `sta_w0[7:0]`, `sta_w1[15:8]`, `sta_w1[7:0]`, `sta_w2[15:8]`, `sta_w2[7:0]`. A difference in any single octet removes this match.
- R4: A destination of six 0xFF octets is accepted even with hashing disabled and no station match.
- R5: With `cfg_hash_en` 1, the hash index is bits 31:26 of a CRC register. The register is seeded with all ones and updated per octet, least significant bit first, with the reflected polynomial 0xEDB88320; no final inversion is applied. Index bits 5:4 pick `hash_w0`..`hash_w3` (value k picks `hash_wk`), and index bits 3:0 pick the bit inside that word. The frame passes when that bit is 1.
- R6: With `cfg_hash_en` 0, an address that is neither the station address nor broadcast is rejected, whatever the hash table holds.
- R7: `decide_valid` rises in the cycle after the sixth octet is sampled. The verdict then stays unchanged until a sampled `frame_start`, after which `decide_valid` is 0 in the next cycle.
- R8: Octets after the sixth, and cycles with `oct_valid` low, do not change the verdict.
- R9: After reset `decide_valid` and `accept` are 0.
- R10: An octet presented in the same cycle as `frame_start` is octet 0 of the new frame.
- R11: `accept` is 0 whenever `decide_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_en | input | 1 | Reception enable |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_hash_en | input | 1 | Enable multicast hash lookup |
| sta_w0 | input | 16 | Station address octets 0 (high) and 1 (low) |
| sta_w1 | input | 16 | Station address octets 2 (high) and 3 (low) |
| sta_w2 | input | 16 | Station address octets 4 (high) and 5 (low) |
| hash_w0 | input | 16 | Hash table word for index bits 5:4 = 0 |
| hash_w1 | input | 16 | Hash table word for index bits 5:4 = 1 |
| hash_w2 | input | 16 | Hash table word for index bits 5:4 = 2 |
| hash_w3 | input | 16 | Hash table word for index bits 5:4 = 3 |
| frame_start | input | 1 | Strobe marking the start of a frame |
| oct_valid | input | 1 | `oct_data` carries a frame octet this cycle |
| oct_data | input | 8 | Frame octet |
| decide_valid | output | 1 | Verdict is present and held |
| accept | output | 1 | Frame passes the filter |

## Verification
The main path is tried with four kinds of address:
- The exact station address, and copies with the first or the last octet altered, which tells a full comparison from a partial one.
- All-ones broadcast, with hashing both off and on.
- Several multicast addresses, each against a table holding only its own bit and against a table holding every bit but its own. This separates a correct index and word order from a wrong one.
- Arbitrary addresses under promiscuous mode and with reception disabled, which shows the mode priority.

Gapped octet streams, trailing extra octets and a strobe that carries octet 0 exercise the stream handling. A long hold exercises the verdict's persistence.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int unsigned OCT_W    = 8;
    localparam int unsigned N_OCT    = 6;
    localparam int unsigned CNT_W    = $clog2(N_OCT + 1);
    localparam int unsigned HWORD_W  = 16;
    localparam int unsigned HWORDS   = 4;
    localparam int unsigned IDX_W    = $clog2(HWORD_W * HWORDS);
    localparam int unsigned SEL_W    = $clog2(HWORDS);
    localparam int unsigned BIT_W    = $clog2(HWORD_W);
    localparam int unsigned CRC_W    = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef struct packed {
        logic uni_ok;
        logic bc_ok;
    } match_st_t;

    typedef struct packed {
        logic valid;
        logic acc;
    } verdict_st_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [OCT_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-OCT_W){1'b0}}, b};
        for (int i = 0; i < OCT_W; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/rxf_octet_tracker.sv
module rxf_octet_tracker
    import rxf_pkg::*;
#(
    parameter int unsigned NO = N_OCT,
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          oct_valid,
    output logic          oct_take,
    output logic [CW-1:0] oct_idx,
    output logic          oct_last
);
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        oct_idx  = frame_start ? '0 : cnt_q;
        oct_take = oct_valid && (oct_idx < CW'(NO));
        oct_last = oct_take && (oct_idx == CW'(NO - 1));
        cnt_d    = oct_take ? oct_idx + CW'(1) : oct_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(NO));
endmodule

// File: rtl/rxf_crc_engine.sv
module rxf_crc_engine
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             oct_take,
    input  logic [OCT_W-1:0] oct_data,
    output logic [IDX_W-1:0] hash_idx
);
    logic [CRC_W-1:0] crc_q, crc_d, crc_cur;

    always_comb begin
        crc_cur  = frame_start ? CRC_SEED : crc_q;
        crc_d    = oct_take ? crc_step(crc_cur, oct_data) : crc_cur;
        hash_idx = crc_d[CRC_W-1 -: IDX_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

    // R10
    seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !oct_take) |=> (crc_q == CRC_SEED));
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
    import rxf_pkg::*;
#(
    parameter int unsigned NO = N_OCT,
    parameter int unsigned CW = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             oct_take,
    input  logic [CW-1:0]    oct_idx,
    input  logic [OCT_W-1:0] oct_data,
    input  logic [OCT_W-1:0] station_oct [NO],
    output logic             uni_hit,
    output logic             bc_hit
);
    match_st_t st_q, st_d, st_cur;
    logic [OCT_W-1:0] want;

    always_comb begin
        st_cur = frame_start ? '{uni_ok: 1'b1, bc_ok: 1'b1} : st_q;
        want   = station_oct[oct_idx];
        st_d   = st_cur;
        if (oct_take) begin
            st_d.uni_ok = st_cur.uni_ok && (oct_data == want);
            st_d.bc_ok  = st_cur.bc_ok  && (oct_data == '1);
        end
        uni_hit = st_d.uni_ok;
        bc_hit  = st_d.bc_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{uni_ok: 1'b1, bc_ok: 1'b1};
        else        st_q <= st_d;
    end

    // R4
    bc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_take && oct_data != '1) |=> !st_q.bc_ok);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_rx_en,
    input  logic               cfg_promisc,
    input  logic               cfg_hash_en,
    input  logic [HWORD_W-1:0] sta_w0,
    input  logic [HWORD_W-1:0] sta_w1,
    input  logic [HWORD_W-1:0] sta_w2,
    input  logic [HWORD_W-1:0] hash_w0,
    input  logic [HWORD_W-1:0] hash_w1,
    input  logic [HWORD_W-1:0] hash_w2,
    input  logic [HWORD_W-1:0] hash_w3,
    input  logic               frame_start,
    input  logic               oct_valid,
    input  logic [OCT_W-1:0]   oct_data,
    output logic               decide_valid,
    output logic               accept
);
    localparam int unsigned OPW = HWORD_W / OCT_W;

    logic [HWORD_W-1:0] swords [N_OCT / OPW];
    logic [HWORD_W-1:0] hwords [HWORDS];
    logic [OCT_W-1:0]   station_oct [N_OCT];

    assign swords[0] = sta_w0;
    assign swords[1] = sta_w1;
    assign swords[2] = sta_w2;
    assign hwords[0] = hash_w0;
    assign hwords[1] = hash_w1;
    assign hwords[2] = hash_w2;
    assign hwords[3] = hash_w3;

    // first octet of each word sits in the upper byte
    for (genvar k = 0; k < N_OCT; k++) begin : g_sta
        assign station_oct[k] =
            swords[k / OPW][HWORD_W - 1 - (k % OPW) * OCT_W -: OCT_W];
    end

    logic             oct_take, oct_last, uni_hit, bc_hit;
    logic [CNT_W-1:0] oct_idx;
    logic [IDX_W-1:0] hash_idx;
    logic             hash_bit;

    rxf_octet_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .oct_valid(oct_valid), .oct_take(oct_take), .oct_idx(oct_idx),
        .oct_last(oct_last));

    rxf_crc_engine u_crc (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .oct_take(oct_take), .oct_data(oct_data), .hash_idx(hash_idx));

    rxf_addr_match u_match (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .oct_take(oct_take), .oct_idx(oct_idx), .oct_data(oct_data),
        .station_oct(station_oct), .uni_hit(uni_hit), .bc_hit(bc_hit));

    verdict_st_t vd_q, vd_d;

    always_comb begin
        hash_bit = hwords[hash_idx[IDX_W-1 -: SEL_W]][hash_idx[BIT_W-1:0]];
        vd_d = vd_q;
        if (frame_start) vd_d = '0;
        if (oct_last) begin
            vd_d.valid = 1'b1;
            vd_d.acc   = cfg_rx_en &&
                         (cfg_promisc || uni_hit || bc_hit ||
                          (cfg_hash_en && hash_bit));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vd_q <= '0;
        else        vd_q <= vd_d;
    end

    assign decide_valid = vd_q.valid;
    assign accept       = vd_q.acc;

    // R11
    acc_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> decide_valid);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_valid && !frame_start) |=> (decide_valid && $stable(accept)));
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !decide_valid);
    // R1
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_last && !cfg_rx_en) |=> (decide_valid && !accept));
    // R2
    promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_last && cfg_rx_en && cfg_promisc) |=> accept);
endmodule

// File: tb/rx_dest_filter_test.sv
`timescale 1ns/100ps
module rx_dest_filter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rx_en = 0, cfg_promisc = 0, cfg_hash_en = 0;
    logic [15:0] sta_w0 = 16'h0a1b, sta_w1 = 16'h2c3d, sta_w2 = 16'h4e5f;
    logic [15:0] hw0 = 0, hw1 = 0, hw2 = 0, hw3 = 0;
    logic frame_start = 0, oct_valid = 0;
    logic [7:0] oct_data = 0;
    logic decide_valid, accept;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rx_dest_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en),
        .cfg_promisc(cfg_promisc), .cfg_hash_en(cfg_hash_en),
        .sta_w0(sta_w0), .sta_w1(sta_w1), .sta_w2(sta_w2),
        .hash_w0(hw0), .hash_w1(hw1), .hash_w2(hw2), .hash_w3(hw3),
        .frame_start(frame_start), .oct_valid(oct_valid),
        .oct_data(oct_data), .decide_valid(decide_valid), .accept(accept));

    function automatic logic [5:0] ref_idx(input logic [7:0] d [6]);
        logic [31:0] c = 32'hffffffff;
        for (int i = 0; i < 6; i++) begin
            c = c ^ {24'h0, d[i]};
            for (int j = 0; j < 8; j++)
                c = c[0] ? ((c >> 1) ^ 32'hedb88320) : (c >> 1);
        end
        return c[31:26];
    endfunction

    function automatic logic ref_accept(input logic [7:0] d [6]);
        logic [47:0] st = {sta_w0, sta_w1, sta_w2};
        logic [15:0] w [4] = '{hw0, hw1, hw2, hw3};
        logic [5:0] ix = ref_idx(d);
        logic uni = 1, bc = 1;
        for (int i = 0; i < 6; i++) begin
            if (d[i] != st[47 - 8*i -: 8]) uni = 0;
            if (d[i] != 8'hff) bc = 0;
        end
        if (!cfg_rx_en) return 0;
        if (cfg_promisc || uni || bc) return 1;
        return cfg_hash_en && w[ix[5:4]][ix[3:0]];
    endfunction

    // behavioural reference, updated on the same edge the design samples
    int m_cnt = 0;
    logic m_valid = 0, m_acc = 0;
    logic [7:0] m_dest [6];
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_valid = 0; m_acc = 0;
        end else begin
            if (frame_start) begin m_cnt = 0; m_valid = 0; m_acc = 0; end
            if (oct_valid && m_cnt < 6) begin
                m_dest[m_cnt] = oct_data;
                m_cnt++;
                if (m_cnt == 6) begin m_valid = 1; m_acc = ref_accept(m_dest); end
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // R7 R11: compare against the reference on every clock
    always @(negedge clk) if (rst_n && !finished) begin
        check("R7 valid", decide_valid, m_valid);
        check("R11 accept", accept, m_acc);
    end

    task automatic send(input logic [7:0] d [6], input bit gap, input int extra,
                        input bit merge);
        frame_start = 1; oct_valid = merge; oct_data = d[0];
        @(negedge clk);
        frame_start = 0;
        for (int i = (merge ? 1 : 0); i < 6; i++) begin
            oct_valid = 1; oct_data = d[i];
            @(negedge clk);
            if (gap) begin oct_valid = 0; oct_data = 8'h00; @(negedge clk); end
        end
        for (int i = 0; i < extra; i++) begin
            oct_valid = 1; oct_data = 8'hff;
            @(negedge clk);
        end
        oct_valid = 0;
    endtask

    task automatic frame_chk(input string tag, input logic [7:0] d [6],
                             input logic exp, input bit gap = 0,
                             input int extra = 0, input bit merge = 0);
        send(d, gap, extra, merge);
        check({tag, " valid"}, decide_valid, 1'b1);
        check(tag, accept, exp);
    endtask

    task automatic only_bit(input logic [5:0] ix, input bit inv);
        logic [63:0] t = 64'h0;
        t[ix] = 1'b1;
        if (inv) t = ~t;
        {hw3, hw2, hw1, hw0} = t;
    endtask

    logic [7:0] a_sta [6] = '{8'h0a, 8'h1b, 8'h2c, 8'h3d, 8'h4e, 8'h5f};
    logic [7:0] a_bc  [6] = '{8'hff, 8'hff, 8'hff, 8'hff, 8'hff, 8'hff};
    logic [7:0] a_rnd [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    logic [7:0] a_b0  [6] = '{8'h0b, 8'h1b, 8'h2c, 8'h3d, 8'h4e, 8'h5f};
    logic [7:0] a_b5  [6] = '{8'h0a, 8'h1b, 8'h2c, 8'h3d, 8'h4e, 8'h5e};
    logic [7:0] mc [4][6] = '{
        '{8'h01, 8'h00, 8'h5e, 8'h00, 8'h00, 8'h01},
        '{8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01},
        '{8'h01, 8'h80, 8'hc2, 8'h00, 8'h00, 8'h00},
        '{8'h01, 8'h00, 8'h5e, 8'h7f, 8'hff, 8'hfa}};

    initial begin
        repeat (3) @(negedge clk);
        check("R9 valid in reset", decide_valid, 1'b0);
        check("R9 accept in reset", accept, 1'b0);
        rst_n = 1;
        @(negedge clk);
        check("R9 valid after reset", decide_valid, 1'b0);

        frame_chk("R1 rx disabled station", a_sta, 1'b0);
        cfg_rx_en = 1;
        frame_chk("R3 station match", a_sta, 1'b1);
        frame_chk("R3 octet0 differs", a_b0, 1'b0);
        frame_chk("R3 octet5 differs", a_b5, 1'b0);
        frame_chk("R4 broadcast hash off", a_bc, 1'b1);
        {hw3, hw2, hw1, hw0} = '1;
        frame_chk("R6 hash off full table", mc[0], 1'b0);
        frame_chk("R6 hash off unicast", a_rnd, 1'b0);

        cfg_hash_en = 1;
        for (int k = 0; k < 4; k++) begin
            only_bit(ref_idx(mc[k]), 0);
            frame_chk("R5 own bit set", mc[k], 1'b1);
            only_bit(ref_idx(mc[k]), 1);
            frame_chk("R5 own bit clear", mc[k], 1'b0);
        end
        {hw3, hw2, hw1, hw0} = '0;
        frame_chk("R4 broadcast hash on empty table", a_bc, 1'b1);

        cfg_promisc = 1;
        frame_chk("R2 promiscuous", a_rnd, 1'b1);
        cfg_rx_en = 0;
        frame_chk("R1 rx disabled promiscuous", a_rnd, 1'b0);
        cfg_rx_en = 1; cfg_promisc = 0; cfg_hash_en = 0;

        frame_chk("R8 gapped station", a_sta, 1'b1, 1, 0, 0);
        frame_chk("R8 trailing octets", a_b5, 1'b0, 0, 4, 0);
        frame_chk("R10 octet with strobe", a_sta, 1'b1, 0, 0, 1);

        repeat (20) @(negedge clk);
        check("R7 held valid", decide_valid, 1'b1);
        check("R7 held verdict", accept, 1'b1);
        frame_start = 1;
        @(negedge clk);
        frame_start = 0;
        check("R7 cleared by strobe", decide_valid, 1'b0);
        check("R11 accept low when cleared", accept, 1'b0);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule